// File: doc/BRIEF.md
# Mailbox Timestamp Capture Unit

This block gives each message mailbox of a frame controller a 16-bit timestamp. It takes a snapshot of a free-running timer whenever a chosen frame event occurs. A mode input selects what the snapshot holds. It is either the full timer word, or a 4-bit cycle counter joined with the upper twelve timer bits.

Receive and transmit use separate triggers. On receive, either the start-of-frame strobe or the end-of-frame strobe is chosen. The snapshot goes into an input capture register. It is copied into the target mailbox only when the frame logic reports that the message was accepted into that mailbox. On transmit, the snapshot is taken either when the pending flag of a mailbox is set or when its acknowledge flag is set. It is written straight into that mailbox.

The CPU reads any mailbox's timestamp through a registered read port.

Top module: `mbx_tstamp_unit`

## Requirements
- R1: With `cap_src_i` = 0 the captured value equals `timer_i` taken in the trigger cycle.
- R2: With `cap_src_i` = 1 the captured value is `cycle_i` in bits [15:12] and `timer_i[15:4]` in bits [11:0].
- R3: With `rx_edge_sel_i` = 0 a receive capture is taken on `sof_i` and `eof_i` is ignored. With `rx_edge_sel_i` = 1 it is taken on `eof_i` and `sof_i` is ignored.
- R4: `icr_o` takes the receive capture on the clock edge that ends the trigger cycle. It holds its value in every cycle without a selected receive trigger.
- R5: A cycle with `rx_accept_i` = 1 writes the input capture register into mailbox `rx_idx_i`. The value written is the one present after that cycle's own capture, if there is one. Without `rx_accept_i` no receive write occurs.
- R6: With `tx_event_sel_i` = 0 a transmit capture is taken on `tx_pend_set_i` for mailbox `tx_pend_idx_i`, and acknowledge events are ignored. With `tx_event_sel_i` = 1 it is taken on `tx_ack_set_i` for mailbox `tx_ack_idx_i`, and pending events are ignored.
- R7: A transmit capture writes the captured value into its mailbox. A receive write and a transmit write to different mailboxes in the same cycle both take effect.
- R8: `rd_data_o` shows the timestamp of mailbox `rd_idx_i` one clock after `rd_idx_i` is presented. If a write hits that mailbox in the same cycle, the old value is returned and the new value is stored.
- R9: When a receive write and a transmit write target the same mailbox in one cycle, the receive value is stored.
- R10: Reset clears every timestamp, the input capture register and `rd_data_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| timer_i | input | TS_W | Free-running timer |
| cycle_i | input | CYC_W | Cycle counter |
| cap_src_i | input | 1 | 0: raw timer, 1: cycle count joined with upper timer bits |
| rx_edge_sel_i | input | 1 | 0: receive capture at start of frame, 1: at end of frame |
| tx_event_sel_i | input | 1 | 0: transmit capture on pending set, 1: on acknowledge set |
| sof_i | input | 1 | Start-of-frame strobe |
| eof_i | input | 1 | End-of-frame strobe |
| rx_accept_i | input | 1 | Received message accepted into mailbox `rx_idx_i` |
| rx_idx_i | input | IdxW | Receiving mailbox |
| tx_pend_set_i | input | 1 | Transmit pending flag set event |
| tx_pend_idx_i | input | IdxW | Mailbox of the pending event |
| tx_ack_set_i | input | 1 | Transmit acknowledge flag set event |
| tx_ack_idx_i | input | IdxW | Mailbox of the acknowledge event |
| rd_idx_i | input | IdxW | CPU read mailbox index |
| rd_data_o | output | TS_W | Timestamp read data, one cycle latency |
| icr_o | output | TS_W | Input capture register |

## Verification
The bench builds the unit with four mailboxes and the default 16-bit timer and 4-bit cycle widths. This is small enough to sweep every mailbox against every combination of value source, receive edge and transmit event, and to read back the whole array after each write. The bench therefore sees both stray writes to other mailboxes and writes from a trigger that should have been ignored. Directed cycles cover a capture and an accept in the same cycle, a read colliding with a write, a receive write colliding with a transmit write, and a reset taken in the middle of the test.

// File: rtl/mbx_ts_pkg.sv
package mbx_ts_pkg;

    localparam int unsigned TS_W_DEF  = 16;
    localparam int unsigned CYC_W_DEF = 4;
    localparam int unsigned NUM_MB_DEF = 32;

    // Source of the captured word
    typedef enum logic {
        CAP_RAW   = 1'b0,
        CAP_CYCLE = 1'b1
    } cap_src_e;

    // Receive trigger edge
    typedef enum logic {
        RX_AT_SOF = 1'b0,
        RX_AT_EOF = 1'b1
    } rx_edge_e;

    // Transmit trigger event
    typedef enum logic {
        TX_AT_PEND = 1'b0,
        TX_AT_ACK  = 1'b1
    } tx_event_e;

endpackage

// File: rtl/mbx_ts_capval.sv
// Forms the word that every capture samples.
module mbx_ts_capval #(
    parameter int unsigned TS_W  = mbx_ts_pkg::TS_W_DEF,
    parameter int unsigned CYC_W = mbx_ts_pkg::CYC_W_DEF
) (
    input  logic             cap_src_i,
    input  logic [TS_W-1:0]  timer_i,
    input  logic [CYC_W-1:0] cycle_i,
    output logic [TS_W-1:0]  cap_val_o
);
    import mbx_ts_pkg::*;

    localparam int unsigned LowW = TS_W - CYC_W;

    cap_src_e          src;
    logic [TS_W-1:0]   joined;

    assign src    = cap_src_e'(cap_src_i);
    // Cycle count on top, the upper timer bits below it
    assign joined = {cycle_i, timer_i[TS_W-1 -: LowW]};

    generate
        if (CYC_W == 0) begin : g_raw_only
            assign cap_val_o = timer_i;
        end else begin : g_sel
            assign cap_val_o = (src == CAP_CYCLE) ? joined : timer_i;
        end
    endgenerate

endmodule

// File: rtl/mbx_ts_rx_icr.sv
// Receive trigger selection and the input capture register.
module mbx_ts_rx_icr #(
    parameter int unsigned TS_W   = mbx_ts_pkg::TS_W_DEF,
    parameter int unsigned NUM_MB = mbx_ts_pkg::NUM_MB_DEF,
    localparam int unsigned IdxW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rx_edge_sel_i,
    input  logic            sof_i,
    input  logic            eof_i,
    input  logic [TS_W-1:0] cap_val_i,
    input  logic            rx_accept_i,
    input  logic [IdxW-1:0] rx_idx_i,
    output logic [TS_W-1:0] icr_o,
    output logic            wr_en_o,
    output logic [IdxW-1:0] wr_idx_o,
    output logic [TS_W-1:0] wr_val_o
);
    import mbx_ts_pkg::*;

    typedef struct packed {
        logic [TS_W-1:0] icr;
    } rx_st_t;

    rx_st_t   st_d;
    rx_st_t   st_q;
    rx_edge_e edge_sel;
    logic     trig;

    assign edge_sel = rx_edge_e'(rx_edge_sel_i);

    always_comb begin
        st_d = st_q;
        trig = (edge_sel == RX_AT_EOF) ? eof_i : sof_i;
        if (trig) begin
            st_d.icr = cap_val_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign icr_o    = st_q.icr;
    // Commit sees the capture of the same cycle
    assign wr_en_o  = rx_accept_i;
    assign wr_idx_o = rx_idx_i;
    assign wr_val_o = st_d.icr;

endmodule

// File: rtl/mbx_ts_tx_sel.sv
// Chooses which transmit event produces a timestamp write.
module mbx_ts_tx_sel #(
    parameter int unsigned NUM_MB = mbx_ts_pkg::NUM_MB_DEF,
    localparam int unsigned IdxW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic            tx_event_sel_i,
    input  logic            pend_set_i,
    input  logic [IdxW-1:0] pend_idx_i,
    input  logic            ack_set_i,
    input  logic [IdxW-1:0] ack_idx_i,
    output logic            wr_en_o,
    output logic [IdxW-1:0] wr_idx_o
);
    import mbx_ts_pkg::*;

    tx_event_e ev_sel;

    assign ev_sel = tx_event_e'(tx_event_sel_i);

    always_comb begin
        if (ev_sel == TX_AT_ACK) begin
            wr_en_o  = ack_set_i;
            wr_idx_o = ack_idx_i;
        end else begin
            wr_en_o  = pend_set_i;
            wr_idx_o = pend_idx_i;
        end
    end

endmodule

// File: rtl/mbx_ts_store.sv
// Timestamp array: two write ports, one registered read port.
module mbx_ts_store #(
    parameter int unsigned TS_W   = mbx_ts_pkg::TS_W_DEF,
    parameter int unsigned NUM_MB = mbx_ts_pkg::NUM_MB_DEF,
    localparam int unsigned IdxW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            rx_we_i,
    input  logic [IdxW-1:0] rx_idx_i,
    input  logic [TS_W-1:0] rx_val_i,
    input  logic            tx_we_i,
    input  logic [IdxW-1:0] tx_idx_i,
    input  logic [TS_W-1:0] tx_val_i,
    input  logic [IdxW-1:0] rd_idx_i,
    output logic [TS_W-1:0] rd_data_o
);
    typedef struct packed {
        logic [NUM_MB-1:0][TS_W-1:0] ts;
        logic [TS_W-1:0]             rd;
    } store_st_t;

    store_st_t         st_d;
    store_st_t         st_q;
    logic [NUM_MB-1:0] rx_hit;
    logic [NUM_MB-1:0] tx_hit;
    logic              rd_in_range;

    // Per-entry write decode
    generate
        for (genvar g = 0; g < NUM_MB; g++) begin : g_dec
            assign rx_hit[g] = rx_we_i && (rx_idx_i == IdxW'(g));
            assign tx_hit[g] = tx_we_i && (tx_idx_i == IdxW'(g));
        end
    endgenerate

    assign rd_in_range = ({1'b0, rd_idx_i} < (IdxW+1)'(NUM_MB));

    always_comb begin
        st_d = st_q;
        // Read returns the array before this cycle's writes
        st_d.rd = rd_in_range ? st_q.ts[rd_idx_i] : '0;
        for (int i = 0; i < NUM_MB; i++) begin
            if (rx_hit[i]) begin
                st_d.ts[i] = rx_val_i;
            end else if (tx_hit[i]) begin
                st_d.ts[i] = tx_val_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd;

endmodule

// File: rtl/mbx_tstamp_unit.sv
module mbx_tstamp_unit #(
    parameter int unsigned NUM_MB = mbx_ts_pkg::NUM_MB_DEF,
    parameter int unsigned TS_W   = mbx_ts_pkg::TS_W_DEF,
    parameter int unsigned CYC_W  = mbx_ts_pkg::CYC_W_DEF,
    localparam int unsigned IdxW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [TS_W-1:0]  timer_i,
    input  logic [CYC_W-1:0] cycle_i,
    input  logic             cap_src_i,
    input  logic             rx_edge_sel_i,
    input  logic             tx_event_sel_i,
    input  logic             sof_i,
    input  logic             eof_i,
    input  logic             rx_accept_i,
    input  logic [IdxW-1:0]  rx_idx_i,
    input  logic             tx_pend_set_i,
    input  logic [IdxW-1:0]  tx_pend_idx_i,
    input  logic             tx_ack_set_i,
    input  logic [IdxW-1:0]  tx_ack_idx_i,
    input  logic [IdxW-1:0]  rd_idx_i,
    output logic [TS_W-1:0]  rd_data_o,
    output logic [TS_W-1:0]  icr_o
);
    logic [TS_W-1:0] cap_val;
    logic            rx_we;
    logic [IdxW-1:0] rx_widx;
    logic [TS_W-1:0] rx_wval;
    logic            tx_we;
    logic [IdxW-1:0] tx_widx;

    mbx_ts_capval #(
        .TS_W  (TS_W),
        .CYC_W (CYC_W)
    ) capval_i (
        .cap_src_i (cap_src_i),
        .timer_i   (timer_i),
        .cycle_i   (cycle_i),
        .cap_val_o (cap_val)
    );

    mbx_ts_rx_icr #(
        .TS_W   (TS_W),
        .NUM_MB (NUM_MB)
    ) rx_i (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .rx_edge_sel_i (rx_edge_sel_i),
        .sof_i         (sof_i),
        .eof_i         (eof_i),
        .cap_val_i     (cap_val),
        .rx_accept_i   (rx_accept_i),
        .rx_idx_i      (rx_idx_i),
        .icr_o         (icr_o),
        .wr_en_o       (rx_we),
        .wr_idx_o      (rx_widx),
        .wr_val_o      (rx_wval)
    );

    mbx_ts_tx_sel #(
        .NUM_MB (NUM_MB)
    ) tx_i (
        .tx_event_sel_i (tx_event_sel_i),
        .pend_set_i     (tx_pend_set_i),
        .pend_idx_i     (tx_pend_idx_i),
        .ack_set_i      (tx_ack_set_i),
        .ack_idx_i      (tx_ack_idx_i),
        .wr_en_o        (tx_we),
        .wr_idx_o       (tx_widx)
    );

    mbx_ts_store #(
        .TS_W   (TS_W),
        .NUM_MB (NUM_MB)
    ) store_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rx_we_i   (rx_we),
        .rx_idx_i  (rx_widx),
        .rx_val_i  (rx_wval),
        .tx_we_i   (tx_we),
        .tx_idx_i  (tx_widx),
        .tx_val_i  (cap_val),
        .rd_idx_i  (rd_idx_i),
        .rd_data_o (rd_data_o)
    );

endmodule

// File: rtl/mbx_ts_chk.sv
module mbx_ts_chk #(
    parameter int unsigned NUM_MB = mbx_ts_pkg::NUM_MB_DEF,
    parameter int unsigned TS_W   = mbx_ts_pkg::TS_W_DEF,
    parameter int unsigned CYC_W  = mbx_ts_pkg::CYC_W_DEF,
    localparam int unsigned IdxW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [TS_W-1:0]  timer_i,
    input logic [CYC_W-1:0] cycle_i,
    input logic             cap_src_i,
    input logic             rx_edge_sel_i,
    input logic             tx_event_sel_i,
    input logic             sof_i,
    input logic             eof_i,
    input logic             rx_accept_i,
    input logic             tx_pend_set_i,
    input logic             tx_ack_set_i,
    input logic [IdxW-1:0]  rd_idx_i,
    input logic [TS_W-1:0]  rd_data_o,
    input logic [TS_W-1:0]  icr_o
);
    logic            rx_trig;
    logic            any_wr;
    logic            quiet_q;
    logic [IdxW-1:0] idx_q;

    assign rx_trig = rx_edge_sel_i ? eof_i : sof_i;
    assign any_wr  = rx_accept_i || (tx_event_sel_i ? tx_ack_set_i : tx_pend_set_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            quiet_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            quiet_q <= !any_wr;
            idx_q   <= rd_idx_i;
        end
    end

    AST_ICR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rx_trig |=> $stable(icr_o)); // R4

    AST_ICR_RAW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_trig && !cap_src_i) |=> (icr_o == $past(timer_i))); // R1

    AST_ICR_CYC_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_trig && cap_src_i) |=> (icr_o[TS_W-1 -: CYC_W] == $past(cycle_i))); // R2

    AST_ICR_TIMER_FIELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_trig && cap_src_i) |=> (icr_o[TS_W-CYC_W-1:0] == $past(timer_i[TS_W-1:CYC_W]))); // R2

    AST_RD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (quiet_q && (rd_idx_i == idx_q)) |=> $stable(rd_data_o)); // R8

endmodule

bind mbx_tstamp_unit mbx_ts_chk #(
    .NUM_MB (NUM_MB),
    .TS_W   (TS_W),
    .CYC_W  (CYC_W)
) chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .timer_i        (timer_i),
    .cycle_i        (cycle_i),
    .cap_src_i      (cap_src_i),
    .rx_edge_sel_i  (rx_edge_sel_i),
    .tx_event_sel_i (tx_event_sel_i),
    .sof_i          (sof_i),
    .eof_i          (eof_i),
    .rx_accept_i    (rx_accept_i),
    .tx_pend_set_i  (tx_pend_set_i),
    .tx_ack_set_i   (tx_ack_set_i),
    .rd_idx_i       (rd_idx_i),
    .rd_data_o      (rd_data_o),
    .icr_o          (icr_o)
);

// File: tb/mbx_tstamp_unit_tb_top.sv
module mbx_tstamp_unit_tb_top;

    localparam int NMB = 4;
    localparam int TW  = 16;
    localparam int CW  = 4;
    localparam int IW  = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] timer = '0;
    logic [CW-1:0] cycle = '0;
    logic          cap_src = 1'b0;
    logic          rx_edge = 1'b0;
    logic          tx_sel = 1'b0;
    logic          sof = 1'b0;
    logic          eof = 1'b0;
    logic          rx_acc = 1'b0;
    logic [IW-1:0] rx_idx = '0;
    logic          pend = 1'b0;
    logic [IW-1:0] pend_idx = '0;
    logic          ack = 1'b0;
    logic [IW-1:0] ack_idx = '0;
    logic [IW-1:0] rd_idx = '0;
    logic [TW-1:0] rd_data;
    logic [TW-1:0] icr;

    logic [TW-1:0] model [NMB];
    logic [TW-1:0] m_icr;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #2 clk = ~clk;

    mbx_tstamp_unit #(
        .NUM_MB (NMB),
        .TS_W   (TW),
        .CYC_W  (CW)
    ) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .timer_i        (timer),
        .cycle_i        (cycle),
        .cap_src_i      (cap_src),
        .rx_edge_sel_i  (rx_edge),
        .tx_event_sel_i (tx_sel),
        .sof_i          (sof),
        .eof_i          (eof),
        .rx_accept_i    (rx_acc),
        .rx_idx_i       (rx_idx),
        .tx_pend_set_i  (pend),
        .tx_pend_idx_i  (pend_idx),
        .tx_ack_set_i   (ack),
        .tx_ack_idx_i   (ack_idx),
        .rd_idx_i       (rd_idx),
        .rd_data_o      (rd_data),
        .icr_o          (icr)
    );

    function automatic logic [TW-1:0] capf(input logic src, input logic [TW-1:0] t,
                                           input logic [CW-1:0] c);
        return src ? {c, t[TW-1:CW]} : t;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic read_chk(input int mb, input string tag);
        rd_idx = IW'(mb);
        tick();
        chk(tag, rd_data, model[mb]);
    endtask

    task automatic check_all(input string tag);
        for (int mb = 0; mb < NMB; mb++) read_chk(mb, tag);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        sof = 0; eof = 0; rx_acc = 0; pend = 0; ack = 0;
        repeat (3) tick();
        chk("R10 icr in reset", icr, '0);
        chk("R10 rd_data in reset", rd_data, '0);
        rst_n = 1'b1;
        for (int i = 0; i < NMB; i++) model[i] = '0;
        m_icr = '0;
        tick();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog all requirements actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [TW-1:0] ta, tb, old;
        logic [CW-1:0] ca, cb;

        do_reset();
        chk("R10 icr after reset", icr, '0);
        check_all("R10 mailbox after reset");

        // Receive sweep: R1 R2 R3 R4 R5
        for (int vs = 0; vs < 2; vs++) begin
            for (int es = 0; es < 2; es++) begin
                for (int mb = 0; mb < NMB; mb++) begin
                    ta = TW'(16'h0123 + 16'h1111 * mb + 16'h0808 * (vs * 2 + es));
                    tb = ~ta ^ TW'(16'h00F0 * (mb + 1));
                    ca = CW'(mb + 3 * vs + es + 1);
                    cb = ~ca;
                    cap_src = vs[0]; rx_edge = es[0];
                    timer = ta; cycle = ca; sof = 1'b1;
                    tick();
                    sof = 1'b0;
                    if (es == 0) m_icr = capf(vs[0], ta, ca);
                    chk(vs ? "R2 R3 R4 sof capture" : "R1 R3 R4 sof capture", icr, m_icr);
                    timer = tb; cycle = cb; eof = 1'b1;
                    tick();
                    eof = 1'b0;
                    if (es == 1) m_icr = capf(vs[0], tb, cb);
                    chk(vs ? "R2 R3 R4 eof capture" : "R1 R3 R4 eof capture", icr, m_icr);
                    timer = 16'hFFFF; tick();
                    chk("R4 icr holds", icr, m_icr);
                    rx_idx = IW'(mb); rx_acc = 1'b1;
                    tick();
                    rx_acc = 1'b0;
                    model[mb] = m_icr;
                    check_all("R5 receive commit");
                end
            end
        end

        // Capture and accept in the same cycle: R5
        cap_src = 0; rx_edge = 1; timer = 16'hBEEF; eof = 1; rx_acc = 1; rx_idx = 2;
        tick();
        eof = 0; rx_acc = 0;
        m_icr = 16'hBEEF; model[2] = 16'hBEEF;
        chk("R4 icr same-cycle", icr, m_icr);
        read_chk(2, "R5 same-cycle capture commit");

        // Transmit sweep: R1 R2 R6 R7
        for (int vs = 0; vs < 2; vs++) begin
            for (int ts = 0; ts < 2; ts++) begin
                for (int mb = 0; mb < NMB; mb++) begin
                    ta = TW'(16'h3A5C + 16'h2222 * mb + 16'h0505 * (vs * 2 + ts));
                    tb = ta ^ 16'h5A5A;
                    ca = CW'(mb * 5 + vs + ts);
                    cb = CW'(ca + 7);
                    cap_src = vs[0]; tx_sel = ts[0];
                    timer = ta; cycle = ca; pend = 1; pend_idx = IW'(mb);
                    tick();
                    pend = 0;
                    if (ts == 0) model[mb] = capf(vs[0], ta, ca);
                    read_chk(mb, vs ? "R2 R6 R7 pend event" : "R1 R6 R7 pend event");
                    timer = tb; cycle = cb; ack = 1; ack_idx = IW'(mb);
                    tick();
                    ack = 0;
                    if (ts == 1) model[mb] = capf(vs[0], tb, cb);
                    read_chk(mb, vs ? "R2 R6 R7 ack event" : "R1 R6 R7 ack event");
                end
                check_all("R7 transmit array");
            end
        end

        // Read colliding with a write: R8
        tx_sel = 1; cap_src = 0; rd_idx = 1; old = model[1];
        timer = 16'h7A5C; ack = 1; ack_idx = 1;
        tick();
        ack = 0;
        chk("R8 read returns old value", rd_data, old);
        model[1] = 16'h7A5C;
        tick();
        chk("R8 new value committed", rd_data, model[1]);

        // Receive and transmit on the same mailbox: R9
        rx_edge = 0; timer = 16'h4444; sof = 1;
        tick();
        sof = 0; m_icr = 16'h4444;
        tx_sel = 0; timer = 16'h9999; pend = 1; pend_idx = 3; rx_acc = 1; rx_idx = 3;
        tick();
        pend = 0; rx_acc = 0;
        model[3] = m_icr;
        read_chk(3, "R9 receive wins collision");

        // Receive and transmit on different mailboxes: R7
        timer = 16'h1357; pend = 1; pend_idx = 3; rx_acc = 1; rx_idx = 0;
        tick();
        pend = 0; rx_acc = 0;
        model[0] = m_icr; model[3] = 16'h1357;
        check_all("R7 dual write different mailboxes");

        // Reset in mid-run: R10
        do_reset();
        chk("R10 icr cleared", icr, '0);
        check_all("R10 mailbox cleared");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule